// File: doc/BRIEF.md
# Ethernet receive header validator

This block watches an Ethernet receive byte stream, one byte per clock, starting at the first destination-address byte and ending with the last of the four frame check bytes. While the frame passes it picks out the header fields it cares about and compares them with the node's configured station address and IPv4 address. It also sums the IPv4 header for its checksum and counts the frame length. On the cycle after the last byte it gives a single verdict: drop, or the kind of reply the frame calls for. The kinds are an address-resolution request, an ICMP echo request, or a UDP datagram. Failed frames are dropped without any report.

The input side is a plain valid stream and has no back-pressure. The block always takes a byte when `in_valid` is high, so a source that cannot pause can feed it directly. Frames may follow one another with no idle cycle between them. The frame check result is computed outside the block and is read only together with the last byte. The verdict pulse is an output-only strobe with no ready. A consumer that needs it must capture it in that cycle.

Top module: `rx_hdr_validator`

## Requirements
- R1: `verdict_valid` is high for exactly the one cycle after each clock that takes a byte with `in_last` high, and is low at all other times, including after reset. `verdict_type` encodes 0 = drop, 1 = address resolution request, 2 = ICMP echo request, 3 = UDP.
- R2: A frame whose `in_crc_ok` is low at its last byte gets verdict 0.
- R3: A frame whose source address has bit 0 of byte 6 set (the group bit) gets verdict 0.
- R4: A frame of n bytes, counting header and the 4 check bytes, gets verdict 0 when n > MAX_FRAME (1536 by default). No minimum is enforced beyond the checked fields lying ahead of the check bytes. That needs n >= 46 for resolution, n >= 40 for ICMP and n >= 44 for UDP.
- R5: Verdict 1 needs all of the following. Bytes 12..13 are 0x0806. Bytes 14..21 are 00 01 08 00 06 04 00 01. Bytes 38..41 equal `cfg_ip`, most significant byte first. Bytes 0..5 and the sender fields are ignored.
- R6: An IPv4 verdict (2 or 3) needs all of the following. Bytes 0..5 equal `cfg_mac`, most significant byte first. Bytes 12..13 are 0x0800 and byte 14 is 0x45. In byte 20 bit 5 (more fragments) and bits 4:0 are zero, and byte 21 is zero, while bit 6 (don't fragment) is allowed. Byte 22 (TTL) is nonzero. Bytes 30..33 equal `cfg_ip`.
- R7: An IPv4 verdict needs the ones-complement sum of the ten big-endian 16-bit words in bytes 14..33 to equal 0xFFFF.
- R8: An IPv4 verdict needs the total length L in bytes 16..17 to satisfy L + 18 <= n.
- R9: Verdict 2 needs byte 23 = 1, byte 34 = 8 and byte 35 = 0.
- R10: Verdict 3 needs byte 23 = 17, a source port (bytes 34..35) of at least 1024, and a UDP length U in bytes 38..39 with U + 20 <= L. The UDP checksum has no effect.
- R11: Each frame is judged only on its own bytes, including when it follows the previous frame with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mac | input | 48 | Station address of this node |
| cfg_ip | input | 32 | IPv4 address of this node |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte is the last of the frame |
| in_crc_ok | input | 1 | Frame check result, read with the last byte |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_type | output | 2 | Verdict code, see R1 |

## Verification
The bench builds the block with its default MAX_FRAME of 1536. At that value the frames of exactly 1536 and 1537 bytes, the two sides of the length limit, fit well inside the run. It uses a single station and IPv4 address for the node. Random frames are built valid and then have one header byte corrupted, the checksum sometimes repaired, the length cut short or the check flag cleared. That lets each separate field rule decide some verdicts on its own.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
  typedef enum logic [1:0] {
    VT_DROP = 2'd0,
    VT_ARP  = 2'd1,
    VT_ICMP = 2'd2,
    VT_UDP  = 2'd3
  } verdict_t;

  localparam logic [15:0] ETYPE_ARP  = 16'h0806;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  PROTO_ICMP = 8'd1;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
  localparam int          ETH_HDR    = 14;
  localparam int          FCS_BYTES  = 4;
  localparam int          IP_HDR     = 20;
  localparam int          MIN_ARP    = 46;
  localparam int          MIN_ICMP   = 40;
  localparam int          MIN_UDP    = 44;
endpackage

// File: rtl/rxv_pos.sv
module rxv_pos #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  output logic [POS_W-1:0] pos
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (in_valid) begin
      if (in_last) pos <= '0;
      else if (pos != '1) pos <= pos + 1'b1;
    end
  end

  assert_pos_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_last) |-> (pos == '0));
endmodule

// File: rtl/rxv_csum.sv
module rxv_csum #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       in_data,
  output logic             csum_good
);
  import rxv_pkg::*;
  localparam int ACC_W = 20;

  logic [ACC_W-1:0] acc;
  logic [16:0]      fold1;
  logic [15:0]      fold2;
  int               p;

  always_comb p = int'(pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (in_valid) begin
      if (in_last) acc <= '0;
      else if (p >= ETH_HDR && p < ETH_HDR + IP_HDR) begin
        if (pos[0]) acc <= acc + {12'd0, in_data};
        else        acc <= acc + {4'd0, in_data, 8'd0};
      end
    end
  end

  always_comb begin
    fold1     = {1'b0, acc[15:0]} + {13'd0, acc[ACC_W-1:16]};
    fold2     = fold1[15:0] + {15'd0, fold1[16]};
    csum_good = (fold2 == 16'hFFFF);
  end
endmodule

// File: rtl/rxv_fields.sv
module rxv_fields #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       in_data,
  input  logic [47:0]      cfg_mac,
  input  logic [31:0]      cfg_ip,
  output logic             mac_bad,
  output logic             src_bad,
  output logic             arp_bad,
  output logic             ip_bad,
  output logic             icmp_bad,
  output logic             udp_bad,
  output logic [15:0]      etype,
  output logic [7:0]       proto,
  output logic [15:0]      ip_len,
  output logic [15:0]      udp_len
);
  int p;
  always_comb p = int'(pos);

  function automatic logic [7:0] mac_byte(logic [47:0] m, int k);
    return m[8*(5-k) +: 8];
  endfunction

  function automatic logic [7:0] ip_byte(logic [31:0] a, int k);
    return a[8*(3-k) +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || (in_valid && in_last)) begin
      mac_bad <= 1'b0; src_bad <= 1'b0; arp_bad <= 1'b0; ip_bad <= 1'b0;
      icmp_bad <= 1'b0; udp_bad <= 1'b0;
      etype <= '0; proto <= '0; ip_len <= '0; udp_len <= '0;
    end else if (in_valid) begin
      if (p < 6 && in_data != mac_byte(cfg_mac, p)) mac_bad <= 1'b1;
      if (p >= 30 && p < 34 && in_data != ip_byte(cfg_ip, p - 30)) ip_bad <= 1'b1;
      if (p >= 38 && p < 42 && in_data != ip_byte(cfg_ip, p - 38)) arp_bad <= 1'b1;
      case (p)
        6:  if (in_data[0]) src_bad <= 1'b1;
        12: etype[15:8] <= in_data;
        13: etype[7:0]  <= in_data;
        14: begin
          if (in_data != 8'h00) arp_bad <= 1'b1;
          if (in_data != 8'h45) ip_bad  <= 1'b1;
        end
        15: if (in_data != 8'h01) arp_bad <= 1'b1;
        16: begin
          if (in_data != 8'h08) arp_bad <= 1'b1;
          ip_len[15:8] <= in_data;
        end
        17: begin
          if (in_data != 8'h00) arp_bad <= 1'b1;
          ip_len[7:0] <= in_data;
        end
        18: if (in_data != 8'h06) arp_bad <= 1'b1;
        19: if (in_data != 8'h04) arp_bad <= 1'b1;
        20: begin
          if (in_data != 8'h00) arp_bad <= 1'b1;
          if (in_data[5] || in_data[4:0] != 5'd0) ip_bad <= 1'b1;
        end
        21: begin
          if (in_data != 8'h01) arp_bad <= 1'b1;
          if (in_data != 8'h00) ip_bad  <= 1'b1;
        end
        22: if (in_data == 8'h00) ip_bad <= 1'b1;
        23: proto <= in_data;
        34: begin
          if (in_data != 8'h08) icmp_bad <= 1'b1;
          if (in_data < 8'h04)  udp_bad  <= 1'b1;
        end
        35: if (in_data != 8'h00) icmp_bad <= 1'b1;
        38: udp_len[15:8] <= in_data;
        39: udp_len[7:0]  <= in_data;
        default: ;
      endcase
    end
  end

  assert_group_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last && pos == 6 && in_data[0]) |=> src_bad);
endmodule

// File: rtl/rx_hdr_validator.sv
module rx_hdr_validator #(
  parameter int MAX_FRAME = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] cfg_mac,
  input  logic [31:0] cfg_ip,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_crc_ok,
  output logic        verdict_valid,
  output logic [1:0]  verdict_type
);
  import rxv_pkg::*;
  localparam int POS_W = $clog2(MAX_FRAME + 1);

  logic [POS_W-1:0] pos;
  logic             csum_good;
  logic             mac_bad, src_bad, arp_bad, ip_bad, icmp_bad, udp_bad;
  logic [15:0]      etype, ip_len, udp_len;
  logic [7:0]       proto;
  logic             base_ok, ip_ok;
  int               n_i, ipl, udl;
  verdict_t         vt_next, vt_q;

  rxv_pos #(.POS_W(POS_W)) pos_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .pos(pos));

  rxv_csum #(.POS_W(POS_W)) csum_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .pos(pos), .in_data(in_data), .csum_good(csum_good));

  rxv_fields #(.POS_W(POS_W)) fields_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .pos(pos), .in_data(in_data), .cfg_mac(cfg_mac), .cfg_ip(cfg_ip),
    .mac_bad(mac_bad), .src_bad(src_bad), .arp_bad(arp_bad), .ip_bad(ip_bad),
    .icmp_bad(icmp_bad), .udp_bad(udp_bad), .etype(etype), .proto(proto),
    .ip_len(ip_len), .udp_len(udp_len));

  always_comb begin
    n_i     = int'(pos) + 1;
    ipl     = int'(ip_len);
    udl     = int'(udp_len);
    base_ok = in_crc_ok && !src_bad && (n_i <= MAX_FRAME);
    ip_ok   = base_ok && !mac_bad && (etype == ETYPE_IPV4) && !ip_bad &&
              csum_good && (ipl + ETH_HDR + FCS_BYTES <= n_i);
    vt_next = VT_DROP;
    if (base_ok && etype == ETYPE_ARP && !arp_bad && n_i >= MIN_ARP)
      vt_next = VT_ARP;
    else if (ip_ok && proto == PROTO_ICMP && !icmp_bad && n_i >= MIN_ICMP)
      vt_next = VT_ICMP;
    else if (ip_ok && proto == PROTO_UDP && !udp_bad && n_i >= MIN_UDP &&
             udl + IP_HDR <= ipl)
      vt_next = VT_UDP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      vt_q          <= VT_DROP;
    end else begin
      verdict_valid <= in_valid && in_last;
      vt_q          <= (in_valid && in_last) ? vt_next : VT_DROP;
    end
  end

  assign verdict_type = vt_q;

  assert_strobe_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_last) |-> !verdict_valid);

  assert_crc_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_type != VT_DROP) |-> $past(in_crc_ok));

  assert_len_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_type != VT_DROP) |-> (int'($past(pos)) < MAX_FRAME));

  assert_csum_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && (verdict_type == VT_ICMP || verdict_type == VT_UDP))
      |-> $past(csum_good));
endmodule

// File: tb/rx_hdr_validator_tb.sv
module rx_hdr_validator_tb_top;
  localparam logic [47:0] MY_MAC = 48'h12_34_56_78_9A_BC;
  localparam logic [31:0] MY_IP  = 32'hC0_A8_07_04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_crc_ok = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic verdict_valid;
  logic [1:0] verdict_type;

  always #10 clk = ~clk;

  rx_hdr_validator dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mac(MY_MAC), .cfg_ip(MY_IP),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_crc_ok(in_crc_ok), .verdict_valid(verdict_valid),
    .verdict_type(verdict_type));

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] fr [0:1599];
  int flen;
  bit fcrc;
  bit pend = 1'b0;
  int pend_exp;
  string pend_tag;

  task automatic check_eq(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  function automatic bit csum_ok_ref();
    int s = 0;
    for (int i = 14; i < 34; i += 2) s += {fr[i], fr[i+1]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return s == 32'hFFFF;
  endfunction

  function automatic int ref_verdict();
    int n = flen, L, U;
    if (!fcrc || n > 1536 || n < 14 || fr[6][0]) return 0;
    if ({fr[12], fr[13]} == 16'h0806) begin
      if (n < 46) return 0;
      if ({fr[14], fr[15], fr[16], fr[17], fr[18], fr[19], fr[20], fr[21]} !=
          64'h0001_0800_0604_0001) return 0;
      if ({fr[38], fr[39], fr[40], fr[41]} != MY_IP) return 0;
      return 1;
    end
    if ({fr[12], fr[13]} != 16'h0800 || n < 40) return 0;
    if ({fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]} != MY_MAC) return 0;
    if (fr[14] != 8'h45 || fr[20][5] || fr[20][4:0] != 0 || fr[21] != 0) return 0;
    if (fr[22] == 0 || !csum_ok_ref()) return 0;
    if ({fr[30], fr[31], fr[32], fr[33]} != MY_IP) return 0;
    L = {fr[16], fr[17]};
    if (L + 18 > n) return 0;
    if (fr[23] == 1) return (fr[34] == 8 && fr[35] == 0) ? 2 : 0;
    if (fr[23] == 17) begin
      if (n < 44 || {fr[34], fr[35]} < 1024) return 0;
      U = {fr[38], fr[39]};
      return (U + 20 <= L) ? 3 : 0;
    end
    return 0;
  endfunction

  task automatic fix_csum();
    int s = 0;
    fr[24] = 0; fr[25] = 0;
    for (int i = 14; i < 34; i += 2) s += {fr[i], fr[i+1]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    {fr[24], fr[25]} = ~s[15:0];
  endtask

  // kind: 0 resolution request, 1 ICMP echo, 2 UDP
  task automatic build(int kind, int plen);
    int body;
    for (int i = 0; i < 1600; i++) fr[i] = 8'($urandom);
    fcrc = 1'b1;
    {fr[6], fr[7], fr[8], fr[9], fr[10], fr[11]} = 48'h02_11_22_33_44_55;
    if (kind == 0) begin
      for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
      {fr[12], fr[13]} = 16'h0806;
      {fr[14], fr[15], fr[16], fr[17], fr[18], fr[19], fr[20], fr[21]} =
        64'h0001_0800_0604_0001;
      {fr[38], fr[39], fr[40], fr[41]} = MY_IP;
      flen = 64;
    end else begin
      {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]} = MY_MAC;
      {fr[12], fr[13]} = 16'h0800;
      body = 20 + 8 + plen;
      fr[14] = 8'h45; {fr[16], fr[17]} = 16'(body);
      fr[20] = 8'h40; fr[21] = 8'h00; fr[22] = 8'h40;
      fr[23] = (kind == 1) ? 8'd1 : 8'd17;
      {fr[30], fr[31], fr[32], fr[33]} = MY_IP;
      if (kind == 1) begin
        fr[34] = 8'd8; fr[35] = 8'd0;
      end else begin
        fr[34] = 8'(4 + $urandom_range(0, 250));
        {fr[36], fr[37]} = 16'd801;
        {fr[38], fr[39]} = 16'(8 + plen);
      end
      fix_csum();
      flen = 14 + body;
      if (flen < 60) flen = 60;
      flen += 4;
    end
  endtask

  task automatic drive_frame(string tag, bit gap);
    int exp = ref_verdict();
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      if (i == 0 && pend) begin
        check_eq({pend_tag, " verdict_valid"}, int'(verdict_valid), 1);
        check_eq(pend_tag, int'(verdict_type), pend_exp);
        pend = 1'b0;
      end
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == flen - 1);
      in_crc_ok = fcrc;
    end
    pend = 1'b1; pend_exp = exp; pend_tag = tag;
    if (gap) begin
      @(negedge clk);
      check_eq({tag, " verdict_valid"}, int'(verdict_valid), 1);
      check_eq(tag, int'(verdict_type), exp);
      pend = 1'b0;
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      check_eq({tag, " R1 strobe ends"}, int'(verdict_valid), 0);
    end
  endtask

  task automatic expect_frame(string tag, int exp);
    check_eq({tag, " model"}, ref_verdict(), exp);
    drive_frame(tag, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check_eq("R1 reset verdict_valid", int'(verdict_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 idle verdict_valid", int'(verdict_valid), 0);

    build(0, 0); expect_frame("R5 resolution ok", 1);
    build(0, 0); {fr[0], fr[1]} = 16'h0BAD; expect_frame("R5 dst ignored", 1);
    build(0, 0); fr[41] ^= 8'h01; expect_frame("R5 target ip", 0);
    build(0, 0); fr[21] = 8'h02; expect_frame("R5 opcode", 0);
    build(0, 0); flen = 46; expect_frame("R4 resolution 46", 1);
    build(0, 0); flen = 45; expect_frame("R4 resolution 45", 0);
    build(1, 16); expect_frame("R9 icmp ok", 2);
    build(1, 16); fr[34] = 8'd0; fix_csum(); expect_frame("R9 icmp type", 0);
    build(1, 16); fr[35] = 8'd1; expect_frame("R9 icmp code", 0);
    build(2, 20); expect_frame("R10 udp ok", 3);
    build(2, 20); {fr[34], fr[35]} = 16'd1023; expect_frame("R10 port 1023", 0);
    build(2, 20); {fr[34], fr[35]} = 16'd1024; expect_frame("R10 port 1024", 3);
    build(2, 20); {fr[38], fr[39]} = 16'd29; expect_frame("R10 udp len over", 0);
    build(2, 20); {fr[38], fr[39]} = 16'd28; expect_frame("R10 udp len exact", 3);
    build(2, 20); fr[6] = 8'h03; expect_frame("R3 group src", 0);
    build(2, 20); fcrc = 1'b0; expect_frame("R2 crc bad", 0);
    build(2, 20); fr[5] ^= 8'h80; expect_frame("R6 dst mac", 0);
    build(2, 20); fr[20] = 8'h60; fix_csum(); expect_frame("R6 more frags", 0);
    build(2, 20); fr[21] = 8'h01; fix_csum(); expect_frame("R6 frag offset", 0);
    build(2, 20); fr[20] = 8'h00; fix_csum(); expect_frame("R6 no df", 3);
    build(2, 20); fr[22] = 8'h00; fix_csum(); expect_frame("R6 ttl zero", 0);
    build(2, 20); fr[33] ^= 8'h10; fix_csum(); expect_frame("R6 dst ip", 0);
    build(2, 20); fr[25] ^= 8'h01; expect_frame("R7 bad checksum", 0);
    build(2, 20); {fr[16], fr[17]} = 16'(flen - 18); fix_csum();
    expect_frame("R8 length exact", 3);
    build(2, 20); {fr[16], fr[17]} = 16'(flen - 17); fix_csum();
    expect_frame("R8 length over", 0);
    build(2, 1490); expect_frame("R4 frame 1536", 3);
    build(2, 1490); flen = 1537; expect_frame("R4 frame 1537", 0);

    // R11: back-to-back frames, bad then good, no idle cycle
    build(2, 20); fr[25] ^= 8'h01; drive_frame("R11 first bad", 1'b0);
    build(1, 8); drive_frame("R11 second good", 1'b0);
    build(0, 0); drive_frame("R11 third good", 1'b1);

    for (int k = 0; k < 300; k++) begin
      int kind = $urandom_range(0, 2);
      build(kind, $urandom_range(0, 120));
      case ($urandom_range(0, 5))
        0: ;
        1: fcrc = 1'b0;
        2: flen = $urandom_range(20, flen);
        default: begin
          fr[$urandom_range(0, 41)] ^= 8'($urandom_range(1, 255));
          if ($urandom_range(0, 1) == 1 && kind != 0) fix_csum();
        end
      endcase
      drive_frame("R11 random frame", ($urandom_range(0, 3) == 0));
    end
    if (pend) begin
      @(negedge clk);
      check_eq({pend_tag, " verdict_valid"}, int'(verdict_valid), 1);
      check_eq(pend_tag, int'(verdict_type), pend_exp);
      in_valid = 1'b0; in_last = 1'b0; pend = 1'b0;
    end
    @(negedge clk);
    check_eq("R1 final idle", int'(verdict_valid), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule